// File: doc/BRIEF.md
# Masked Offset Frame Word Comparator

This block watches the byte stream of a received frame and evaluates a pool of masked 16-bit word comparisons. Each pool entry names a byte offset, a compare value, a bit mask and one of four anchor points: the first byte of the frame, the first byte after the EtherType, the first byte after the IP header, or the first byte after the TCP/UDP header. The positions of the last three anchors come from a header parser outside this block. An entry captures the two bytes at anchor plus offset and anchor plus offset plus one, then tests them under its mask.

Several screeners read the one shared pool. Each screener holds three pointers (A, B, C). When a frame ends, the block raises a done strobe for one cycle and presents an A, B and C match bit for every screener. Each bit is the result of the pool entry that its pointer selects. Three entries with full masks at adjacent word offsets together match any 48-bit field, such as a station address. A screening stage downstream combines these bits with its other match terms.

Top module: `frame_word_cmp`

## Requirements
- R1: A pool entry is true when the captured word ANDed with the entry mask equals the entry value ANDed with the same mask.
- R2: In the captured word, bits 7:0 hold the byte at anchor plus offset and bits 15:8 hold the byte one position later.
- R3: Byte positions count from 0 at the first byte of a frame. The offset field holds 0 to 127 and is added to the position of the selected anchor.
- R4: The 2-bit anchor select of an entry chooses among four anchors. Code 0 is frame start, at position 0 and always present. Code 1 is the end of the EtherType, code 2 the end of the IP header, and code 3 the end of the TCP/UDP header. Codes 1, 2 and 3 take their position from `anc_pos` slots 0, 1 and 2 and their presence from `anc_vld` bits 0, 1 and 2.
- R5: An entry whose anchor is not flagged present when its target bytes go by is false.
- R6: An entry is false when the frame ends before the byte at anchor plus offset plus one is received.
- R7: Each pointer is 5 bits wide. Screener s takes pointer A from `scr_ptr` bits [15s+4:15s], pointer B from the next 5 bits and pointer C from the 5 bits after those. `match_a[s]`, `match_b[s]` and `match_c[s]` equal the result of the selected entry.
- R8: A pointer value of 24 or above selects no entry, and its match bit is 0.
- R9: `done` is high for exactly the one cycle after the last byte of a frame is accepted. The match outputs are valid in that cycle and are 0 in every other cycle.
- R10: Captured bytes are cleared at the first byte of each frame, so a result never carries over from an earlier frame.
- R11: A cycle with `in_valid` low does not advance the byte position.
- R12: The A, B and C compares of one screener, pointed at three full-mask entries at adjacent word offsets, together match an arbitrary 48-bit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| anc_pos | input | 3*POS_W | Positions of the EtherType-end, IP-end and L4-end anchors |
| anc_vld | input | 3 | Presence flags of those three anchors |
| cfg_offset | input | NUM_ENTRIES*OFFS_W | Per-entry byte offset |
| cfg_value | input | NUM_ENTRIES*16 | Per-entry compare value |
| cfg_mask | input | NUM_ENTRIES*16 | Per-entry bit mask |
| cfg_anchor | input | NUM_ENTRIES*2 | Per-entry anchor select |
| scr_ptr | input | NUM_SCREENERS*3*PTR_W | A, B and C pointers of each screener |
| done | output | 1 | One-cycle strobe after the frame's last byte |
| match_a | output | NUM_SCREENERS | Compare A result of each screener |
| match_b | output | NUM_SCREENERS | Compare B result of each screener |
| match_c | output | NUM_SCREENERS | Compare C result of each screener |

## Verification
The bench keeps the full pool of 24 entries and 5-bit pointers, so every pointer code from 0 to 31 can be reached, including the eight codes that select no entry. It reduces the block to four screeners and a 9-bit position. With that position width, frames of up to 200 bytes and the offset limit of 127 fit well inside the counter range. The bench runs several hundred randomized frames with gaps between bytes, anchors present and absent, and values drawn from the frame itself with single bits flipped. Directed frames cover byte order, the 127-byte offset at the frame-length boundary, a 48-bit address match, carry-over between frames, and out-of-range pointers.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned WORD_W     = 16;
   localparam int unsigned ANCH_NUM   = 4;
   localparam int unsigned ANCH_SEL_W = 2;
   localparam int unsigned PICKS      = 3;  // A, B, C per screener

   // anchor select codes; the order is decoded by the entry logic
   typedef enum logic [ANCH_SEL_W-1:0] {
      ANCH_FRAME = 2'd0,
      ANCH_ETYPE = 2'd1,
      ANCH_L3END = 2'd2,
      ANCH_L4END = 2'd3
   } anch_sel_e;
endpackage

// File: rtl/fwc_pos_track.sv
module fwc_pos_track #(
   parameter int unsigned POS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   output logic             first,
   output logic [POS_W-1:0] cur_pos,
   output logic             done
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic             in_frame;
   logic [POS_W-1:0] cnt;

   assign first   = !in_frame;
   assign cur_pos = in_frame ? cnt : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         cnt      <= '0;
         done     <= 1'b0;
      end else begin
         done <= in_valid & in_last;
         if (in_valid) begin
            in_frame <= !in_last;
            cnt      <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
         end
      end
   end

   // R11
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_last && cur_pos != POS_MAX) |=> (cur_pos == $past(cur_pos) + 1'b1));
   // R11
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid) |=> $stable(cur_pos));
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> first);
endmodule

// File: rtl/fwc_entry.sv
module fwc_entry
   import fwc_pkg::*;
#(
   parameter int unsigned POS_W  = 11,
   parameter int unsigned OFFS_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              first,
   input  logic [POS_W-1:0]  cur_pos,
   input  logic [POS_W-1:0]  anc_pos,
   input  logic              anc_vld,
   input  logic [OFFS_W-1:0] offset,
   input  logic [WORD_W-1:0] value,
   input  logic [WORD_W-1:0] mask,
   output logic              hit
);
   localparam int unsigned XW = POS_W + 1;

   logic [XW-1:0]     tgt_lo, tgt_hi, pos_x;
   logic              take_lo, take_hi;
   logic              got_lo, got_hi;
   logic [BYTE_W-1:0] byte_lo, byte_hi;
   logic [WORD_W-1:0] word;

   assign tgt_lo  = {1'b0, anc_pos} + XW'(offset);
   assign tgt_hi  = tgt_lo + 1'b1;
   assign pos_x   = {1'b0, cur_pos};
   assign take_lo = in_valid & anc_vld & (pos_x == tgt_lo);
   assign take_hi = in_valid & anc_vld & (pos_x == tgt_hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         got_lo  <= 1'b0;
         got_hi  <= 1'b0;
         byte_lo <= '0;
         byte_hi <= '0;
      end else if (in_valid) begin
         got_lo <= (got_lo & !first) | take_lo;
         got_hi <= (got_hi & !first) | take_hi;
         if (take_lo)    byte_lo <= in_data;
         else if (first) byte_lo <= '0;
         if (take_hi)    byte_hi <= in_data;
         else if (first) byte_hi <= '0;
      end
   end

   assign word = {byte_hi, byte_lo};
   assign hit  = got_lo & got_hi & ((word & mask) == (value & mask));

   // R6
   hi_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(got_hi) |-> $past(in_valid));
   // R10
   frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && first && !take_lo) |=> !got_lo);
endmodule

// File: rtl/fwc_ptr_pick.sv
module fwc_ptr_pick #(
   parameter int unsigned NUM_ENTRIES = 24,
   parameter int unsigned PTR_W       = 5
) (
   input  logic [NUM_ENTRIES-1:0] hits,
   input  logic [PTR_W-1:0]       ptr,
   output logic                   sel
);
   generate
      if (NUM_ENTRIES == (1 << PTR_W)) begin : g_full
         // every code names an entry
         assign sel = hits[ptr];
      end else begin : g_sparse
         // codes past the pool fall through to 0
         always_comb begin
            sel = 1'b0;
            for (int e = 0; e < NUM_ENTRIES; e++)
               if (ptr == PTR_W'(e)) sel = hits[e];
         end
      end
   endgenerate
endmodule

// File: rtl/frame_word_cmp.sv
module frame_word_cmp
   import fwc_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES   = 24,
   parameter int unsigned NUM_SCREENERS = 8,
   parameter int unsigned OFFS_W        = 7,
   parameter int unsigned PTR_W         = 5,
   parameter int unsigned POS_W         = 11
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   input  logic [BYTE_W-1:0]                     in_data,
   input  logic                                  in_last,
   input  logic [(ANCH_NUM-1)*POS_W-1:0]         anc_pos,
   input  logic [ANCH_NUM-2:0]                   anc_vld,
   input  logic [NUM_ENTRIES*OFFS_W-1:0]         cfg_offset,
   input  logic [NUM_ENTRIES*WORD_W-1:0]         cfg_value,
   input  logic [NUM_ENTRIES*WORD_W-1:0]         cfg_mask,
   input  logic [NUM_ENTRIES*ANCH_SEL_W-1:0]     cfg_anchor,
   input  logic [NUM_SCREENERS*PICKS*PTR_W-1:0]  scr_ptr,
   output logic                                  done,
   output logic [NUM_SCREENERS-1:0]              match_a,
   output logic [NUM_SCREENERS-1:0]              match_b,
   output logic [NUM_SCREENERS-1:0]              match_c
);
   localparam int unsigned NUM_PTRS = NUM_SCREENERS * PICKS;

   generate
      if ((1 << PTR_W) < NUM_ENTRIES) begin : g_bad_ptr
         $error("PTR_W too narrow for NUM_ENTRIES");
      end
      if (POS_W <= OFFS_W) begin : g_bad_pos
         $error("POS_W must exceed OFFS_W");
      end
   endgenerate

   logic             first;
   logic [POS_W-1:0] cur_pos;

   fwc_pos_track #(.POS_W(POS_W)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_last  (in_last),
      .first    (first),
      .cur_pos  (cur_pos),
      .done     (done)
   );

   logic [POS_W-1:0]    anch_pos_a [ANCH_NUM];
   logic [ANCH_NUM-1:0] anch_vld_a;

   always_comb begin
      anch_pos_a[0] = '0;
      anch_vld_a[0] = 1'b1;
      for (int k = 1; k < ANCH_NUM; k++) begin
         anch_pos_a[k] = anc_pos[(k-1)*POS_W +: POS_W];
         anch_vld_a[k] = anc_vld[k-1];
      end
   end

   logic [NUM_ENTRIES-1:0] ent_hit;

   generate
      for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
         logic [ANCH_SEL_W-1:0] asel;
         assign asel = cfg_anchor[e*ANCH_SEL_W +: ANCH_SEL_W];
         fwc_entry #(.POS_W(POS_W), .OFFS_W(OFFS_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .in_data  (in_data),
            .first    (first),
            .cur_pos  (cur_pos),
            .anc_pos  (anch_pos_a[asel]),
            .anc_vld  (anch_vld_a[asel]),
            .offset   (cfg_offset[e*OFFS_W +: OFFS_W]),
            .value    (cfg_value[e*WORD_W +: WORD_W]),
            .mask     (cfg_mask[e*WORD_W +: WORD_W]),
            .hit      (ent_hit[e])
         );
      end
   endgenerate

   logic [NUM_PTRS-1:0] pick;
   logic [NUM_PTRS-1:0] match_all;

   generate
      for (genvar p = 0; p < NUM_PTRS; p++) begin : g_pick
         fwc_ptr_pick #(.NUM_ENTRIES(NUM_ENTRIES), .PTR_W(PTR_W)) u_pick (
            .hits (ent_hit),
            .ptr  (scr_ptr[p*PTR_W +: PTR_W]),
            .sel  (pick[p])
         );
         assign match_all[p] = done & pick[p];

         // R8
         ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (scr_ptr[p*PTR_W +: PTR_W] >= NUM_ENTRIES) |-> !match_all[p]);
      end
      for (genvar s = 0; s < NUM_SCREENERS; s++) begin : g_scr
         assign match_a[s] = match_all[s*PICKS + 0];
         assign match_b[s] = match_all[s*PICKS + 1];
         assign match_c[s] = match_all[s*PICKS + 2];
      end
   endgenerate

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (match_a == '0 && match_b == '0 && match_c == '0));
endmodule

// File: tb/frame_word_cmp_tb.sv
module frame_word_cmp_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NE   = 24;
   localparam int NS   = 4;
   localparam int OW   = 7;
   localparam int PW   = 5;
   localparam int POSW = 9;
   localparam int NP   = NS * 3;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic [7:0]           in_data = '0;
   logic                 in_last = 1'b0;
   logic [3*POSW-1:0]    anc_pos = '0;
   logic [2:0]           anc_vld = '0;
   logic [NE*OW-1:0]     cfg_offset = '0;
   logic [NE*16-1:0]     cfg_value = '0;
   logic [NE*16-1:0]     cfg_mask = '0;
   logic [NE*2-1:0]      cfg_anchor = '0;
   logic [NP*PW-1:0]     scr_ptr = '0;
   logic                 done;
   logic [NS-1:0]        match_a, match_b, match_c;

   frame_word_cmp #(.NUM_ENTRIES(NE), .NUM_SCREENERS(NS), .OFFS_W(OW),
                    .PTR_W(PW), .POS_W(POSW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .anc_pos(anc_pos), .anc_vld(anc_vld),
      .cfg_offset(cfg_offset), .cfg_value(cfg_value), .cfg_mask(cfg_mask),
      .cfg_anchor(cfg_anchor), .scr_ptr(scr_ptr), .done(done),
      .match_a(match_a), .match_b(match_b), .match_c(match_c));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] frm [256];
   int flen;
   int apos [3];
   bit avld [3];
   int e_off [NE];
   int e_val [NE];
   int e_msk [NE];
   int e_anc [NE];
   int ptrv [NP];
   logic [NS-1:0] got_a, got_b, got_c;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_hit(input int e);
      int base, t;
      bit ok;
      int w;
      if (e_anc[e] == 0) begin base = 0; ok = 1'b1; end
      else begin base = apos[e_anc[e]-1]; ok = avld[e_anc[e]-1]; end
      t = base + e_off[e];
      if (!ok || t + 1 >= flen) return 1'b0;
      w = {16'h0, frm[t+1], frm[t]};
      return ((w & e_msk[e]) == (e_val[e] & e_msk[e]));
   endfunction

   task automatic apply_cfg();
      for (int k = 0; k < 3; k++) begin
         anc_pos[k*POSW +: POSW] = POSW'(apos[k]);
         anc_vld[k] = avld[k];
      end
      for (int e = 0; e < NE; e++) begin
         cfg_offset[e*OW +: OW] = OW'(e_off[e]);
         cfg_value[e*16 +: 16]  = 16'(e_val[e]);
         cfg_mask[e*16 +: 16]   = 16'(e_msk[e]);
         cfg_anchor[e*2 +: 2]   = 2'(e_anc[e]);
      end
      for (int p = 0; p < NP; p++) scr_ptr[p*PW +: PW] = PW'(ptrv[p]);
   endtask

   task automatic clear_cfg();
      for (int k = 0; k < 3; k++) begin apos[k] = 0; avld[k] = 1'b0; end
      for (int e = 0; e < NE; e++) begin
         e_off[e] = 0; e_val[e] = 0; e_msk[e] = 16'hFFFF; e_anc[e] = 0;
      end
      for (int p = 0; p < NP; p++) ptrv[p] = 31;
   endtask

   // drive one frame; R7 checks each match bit against the model at done
   task automatic run_frame(input bit gaps);
      apply_cfg();
      for (int i = 0; i < flen; i++) begin
         if (gaps && ($urandom % 3 == 0)) begin
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
         end
         @(negedge clk);
         if (i == flen - 1) chk(done == 1'b0, "R9 done early", done, 0);
         in_valid = 1'b1;
         in_data  = frm[i];
         in_last  = (i == flen - 1);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      chk(done == 1'b1, "R9 done strobe", done, 1);
      got_a = match_a; got_b = match_b; got_c = match_c;
      for (int s = 0; s < NS; s++) begin
         for (int k = 0; k < 3; k++) begin
            int p;
            bit ex, ac;
            p  = s * 3 + k;
            ex = (ptrv[p] < NE) ? exp_hit(ptrv[p]) : 1'b0;
            ac = (k == 0) ? match_a[s] : (k == 1) ? match_b[s] : match_c[s];
            chk(ac == ex, "R1 R7 screener match", ac, ex);
         end
      end
      @(negedge clk);
      chk(done == 1'b0 && match_a == 0 && match_b == 0 && match_c == 0,
          "R9 one-cycle done", {match_a, match_b, match_c, done}, 0);
   endtask

   task automatic rand_cfg();
      for (int k = 0; k < 3; k++) begin
         apos[k] = $urandom % flen;
         avld[k] = ($urandom % 5) != 0;
      end
      for (int e = 0; e < NE; e++) begin
         int base, t;
         bit ok;
         e_anc[e] = $urandom % 4;
         e_off[e] = ($urandom % 2) ? ($urandom % 16) : ($urandom % 128);
         case ($urandom % 5)
            0: e_msk[e] = 16'hFFFF;
            1: e_msk[e] = 16'h0000;
            2: e_msk[e] = 16'h00FF;
            3: e_msk[e] = 16'hFF00;
            default: e_msk[e] = $urandom % 65536;
         endcase
         if (e_anc[e] == 0) begin base = 0; ok = 1'b1; end
         else begin base = apos[e_anc[e]-1]; ok = 1'b1; end
         t = base + e_off[e];
         if (ok && t + 1 < flen && ($urandom % 4) != 0) begin
            e_val[e] = {16'h0, frm[t+1], frm[t]};
            if ($urandom % 2) e_val[e] = e_val[e] ^ (1 << ($urandom % 16));
         end else e_val[e] = $urandom % 65536;
      end
      for (int p = 0; p < NP; p++) ptrv[p] = $urandom % 32;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      clear_cfg();
      apply_cfg();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(done == 1'b0 && match_a == 0 && match_b == 0 && match_c == 0,
          "R9 reset outputs", {match_a, match_b, match_c, done}, 0);

      // R2 byte order: byte at offset is bits 7:0
      clear_cfg();
      flen = 20;
      for (int i = 0; i < flen; i++) frm[i] = 8'h00;
      frm[5] = 8'h12; frm[6] = 8'h34;
      e_off[0] = 5; e_val[0] = 16'h3412;
      e_off[1] = 5; e_val[1] = 16'h1234;
      e_off[2] = 5; e_val[2] = 16'h3400; e_msk[2] = 16'hFF00;  // R1 masked
      ptrv[0] = 0; ptrv[1] = 1; ptrv[2] = 2;
      run_frame(1'b0);
      chk(got_a[0] == 1'b1, "R2 low byte first", got_a[0], 1);
      chk(got_b[0] == 1'b0, "R2 swapped order", got_b[0], 0);
      chk(got_c[0] == 1'b1, "R1 mask hides low byte", got_c[0], 1);

      // R12 48-bit address match across A, B, C
      clear_cfg();
      flen = 64;
      for (int i = 0; i < flen; i++) frm[i] = 8'(i * 37 + 5);
      for (int k = 0; k < 3; k++) begin
         e_off[k] = 2 * k;
         e_val[k] = {16'h0, frm[2*k+1], frm[2*k]};
      end
      ptrv[3] = 0; ptrv[4] = 1; ptrv[5] = 2;
      run_frame(1'b1);
      chk({got_a[1], got_b[1], got_c[1]} == 3'b111, "R12 full address", {got_a[1], got_b[1], got_c[1]}, 7);
      frm[5] = frm[5] ^ 8'h80;
      run_frame(1'b1);
      chk({got_a[1], got_b[1], got_c[1]} == 3'b110, "R12 one bit off", {got_a[1], got_b[1], got_c[1]}, 6);

      // R4 anchors and R5 absent anchor
      clear_cfg();
      flen = 80;
      for (int i = 0; i < flen; i++) frm[i] = 8'(i);
      apos[0] = 14; apos[1] = 34; apos[2] = 42;
      avld[0] = 1'b1; avld[1] = 1'b1; avld[2] = 1'b0;
      for (int k = 1; k < 4; k++) begin
         e_anc[k] = k; e_off[k] = 3;
         e_val[k] = {16'h0, frm[apos[k-1]+4], frm[apos[k-1]+3]};
      end
      ptrv[0] = 1; ptrv[1] = 2; ptrv[2] = 3;
      run_frame(1'b0);
      chk(got_a[0] == 1'b1, "R4 EtherType anchor", got_a[0], 1);
      chk(got_b[0] == 1'b1, "R4 IP anchor", got_b[0], 1);
      chk(got_c[0] == 1'b0, "R5 absent anchor", got_c[0], 0);
      avld[2] = 1'b1;
      run_frame(1'b1);
      chk(got_c[0] == 1'b1, "R4 L4 anchor", got_c[0], 1);

      // R3 offset 127 and R6 frame too short
      clear_cfg();
      flen = 129;
      for (int i = 0; i < flen; i++) frm[i] = 8'(i ^ 8'h5A);
      e_off[0] = 127; e_val[0] = {16'h0, frm[128], frm[127]};
      ptrv[0] = 0;
      run_frame(1'b0);
      chk(got_a[0] == 1'b1, "R3 offset 127", got_a[0], 1);
      flen = 128;
      e_msk[0] = 16'h0000;
      run_frame(1'b0);
      chk(got_a[0] == 1'b0, "R6 frame ends early", got_a[0], 0);
      // R10 no carry-over: long frame matches, short one must not
      flen = 129;
      run_frame(1'b0);
      chk(got_a[0] == 1'b1, "R10 long frame", got_a[0], 1);
      flen = 100;
      run_frame(1'b0);
      chk(got_a[0] == 1'b0, "R10 cleared at frame start", got_a[0], 0);

      // R8 pointer codes 24..31 never match, 23 does
      clear_cfg();
      flen = 40;
      for (int i = 0; i < flen; i++) frm[i] = 8'(i * 3);
      for (int e = 0; e < NE; e++) e_msk[e] = 16'h0000;
      for (int c = 23; c < 32; c++) begin
         ptrv[0] = c;
         run_frame(1'b0);
         chk(got_a[0] == (c < NE), "R8 pointer range", got_a[0], c < NE);
      end

      // R11 gaps: randomized frames with idle cycles, and R1 sweep
      for (int f = 0; f < 300; f++) begin
         flen = 1 + $urandom % 90;
         for (int i = 0; i < flen; i++) frm[i] = 8'($urandom);
         rand_cfg();
         run_frame(f[0]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule